// File: doc/BRIEF.md
# Hybrid Ripple Adder with Accelerated Middle Segment

This block adds two unsigned words and a carry input. Most bit positions use a plain ripple chain. A short window in the middle of the word uses a parallel-prefix (Kogge-Stone) carry network instead. The lower ripple section feeds its carry into the prefix window, and the prefix window's carry then ripples through the upper section.

The window sits in the middle because two kinds of carry chain both cross it: chains that start near the least significant bits and stop mid-word, and chains that start mid-word and run to the top. Making this window fast shortens both kinds of chain. The full-length chain gets a little shorter as well. The same adder can serve as the final vector-merge stage behind a carry-save array.

The word width, the window's lowest bit and the window width are parameters. By default the window is centred: bits 12..19 for a 32-bit word and bits 28..35 for a 64-bit word. Settings that would place the window outside the word are rejected at elaboration.

Top module: `hybrid_ripple_adder`

## Requirements
- R1: With default parameters (32 bits), {cout, sum} equals a + b + cin, taken modulo 2^33.
- R2: With WIDTH set to 64, {cout, sum} equals a + b + cin, taken modulo 2^65.
- R3: A carry entering at cin crosses all three sections when every bit propagates: a all ones, b zero and cin one give sum zero and cout one.
- R4: A carry generated in the lower ripple section that ends inside the prefix window is summed correctly.
- R5: A carry leaving the prefix window and rippling through the upper section to the top of the word, including into cout, is summed correctly.
- R6: When every bit of the prefix window propagates, the window's carry-out equals its carry-in.
- R7: The result is correct for windows placed elsewhere: a window starting at bit 0, and a window ending at the top bit.
- R8: A window extending outside the word, or narrower than 2 bits, stops elaboration with an error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First addend |
| b | input | WIDTH | Second addend |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| cout | output | 1 | Carry out of the top bit |

## Verification
Whenever the inputs are known, the embedded assertions check three things: the full arithmetic result, the carry arriving at the prefix window against the arithmetic carry into that bit, and the window's carry-out on every evaluation. This includes the pass-through of the window's carry-in when the whole window propagates. Only the bench's directed scenarios can show that specific long chains are exercised, as opposed to merely tolerated. These are chains that end inside the window, chains that run from the window to cout, and the full-word chain. Only the bench can show that windows placed at bit 0 or at the top bit still produce the right sum. The elaboration check in R8 is visible only when the block is built with bad parameters.

// File: rtl/hybrid_ripple_adder.sv
module hybrid_ripple_adder #(
  parameter int WIDTH    = 32,
  parameter int FAST_W   = 8,
  parameter int FAST_LSB = WIDTH/2 - FAST_W/2
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int SEG_TOP = FAST_LSB + FAST_W;
  localparam int STAGES  = $clog2(FAST_W);

  generate
    if (FAST_W < 2 || FAST_LSB < 0 || SEG_TOP > WIDTH) begin : g_bad_window
      $error("hybrid_ripple_adder: prefix window [%0d +: %0d] does not fit in %0d bits", FAST_LSB, FAST_W, WIDTH); // R8
    end
  endgenerate

  logic              rc;
  logic              seg_cin, seg_cout;
  logic [FAST_W-1:0] sp, gv, pv;

  always_comb begin
    sum = '0;
    rc  = cin;
    for (int i = 0; i < FAST_LSB; i++) begin
      sum[i] = a[i] ^ b[i] ^ rc;
      rc     = (a[i] & b[i]) | ((a[i] ^ b[i]) & rc);
    end
    seg_cin = rc;

    for (int j = 0; j < FAST_W; j++) begin
      sp[j] = a[FAST_LSB+j] ^ b[FAST_LSB+j];
      gv[j] = a[FAST_LSB+j] & b[FAST_LSB+j];
    end
    pv    = sp;
    gv[0] = gv[0] | (sp[0] & seg_cin);

    for (int s = 0; s < STAGES; s++) begin
      for (int i = FAST_W-1; i >= (1 << s); i--) begin
        if (i < (2 << s)) begin
          gv[i] = gv[i] | (pv[i] & gv[i-(1<<s)]);
          pv[i] = 1'b0;
        end else begin
          gv[i] = gv[i] | (pv[i] & gv[i-(1<<s)]);
          pv[i] = pv[i] & pv[i-(1<<s)];
        end
      end
    end

    sum[FAST_LSB] = sp[0] ^ seg_cin;
    for (int j = 1; j < FAST_W; j++)
      sum[FAST_LSB+j] = sp[j] ^ gv[j-1];
    seg_cout = gv[FAST_W-1];

    rc = seg_cout;
    for (int i = SEG_TOP; i < WIDTH; i++) begin
      sum[i] = a[i] ^ b[i] ^ rc;
      rc     = (a[i] & b[i]) | ((a[i] ^ b[i]) & rc);
    end
    cout = rc;
  end

  localparam logic [WIDTH:0] LO_MASK  = (WIDTH+1)'((65'd1 << FAST_LSB) - 65'd1);
  localparam logic [WIDTH:0] SEG_MASK = (WIDTH+1)'((65'd1 << SEG_TOP) - 65'd1);

  logic [WIDTH:0] ref_full, ref_lo, ref_seg;
  assign ref_full = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
  assign ref_lo   = ({1'b0, a} & LO_MASK) + ({1'b0, b} & LO_MASK) + {{WIDTH{1'b0}}, cin};
  assign ref_seg  = ({1'b0, a} & SEG_MASK) + ({1'b0, b} & SEG_MASK) + {{WIDTH{1'b0}}, cin};

  always_comb begin
    if (!$isunknown({a, b, cin})) begin
      AST_RESULT_EXACT: assert ({cout, sum} == ref_full); // R1
      AST_SEG_CIN_ARITH: assert (seg_cin == ref_lo[FAST_LSB]); // R4
      AST_SEG_COUT_ARITH: assert (seg_cout == ref_seg[SEG_TOP]); // R5
      AST_SEG_PASS_THROUGH: assert (!(&sp) || (seg_cout == seg_cin)); // R6
    end
  end
endmodule

// File: tb/hybrid_ripple_adder_bench.sv
module hybrid_ripple_adder_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  logic [63:0] av = '0, bv = '0;
  logic        ci = 1'b0;

  logic [31:0] s32;  logic c32;
  logic [63:0] s64;  logic c64;
  logic [15:0] s16a; logic c16a;
  logic [15:0] s16b; logic c16b;

  hybrid_ripple_adder u_hybrid_ripple_adder (
    .a(av[31:0]), .b(bv[31:0]), .cin(ci), .sum(s32), .cout(c32));
  hybrid_ripple_adder #(.WIDTH(64)) u_hybrid_ripple_adder_w64 (
    .a(av), .b(bv), .cin(ci), .sum(s64), .cout(c64));
  hybrid_ripple_adder #(.WIDTH(16), .FAST_W(4), .FAST_LSB(0)) u_hybrid_ripple_adder_bot (
    .a(av[15:0]), .b(bv[15:0]), .cin(ci), .sum(s16a), .cout(c16a));
  hybrid_ripple_adder #(.WIDTH(16), .FAST_W(8), .FAST_LSB(8)) u_hybrid_ripple_adder_top (
    .a(av[15:0]), .b(bv[15:0]), .cin(ci), .sum(s16b), .cout(c16b));

  task automatic chk(string tag, logic [64:0] act, logic [64:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [63:0] x, logic [63:0] y, logic c, string tag);
    logic [64:0] e64, e32, e16;
    av = x; bv = y; ci = c;
    #1;
    e64 = {1'b0, x} + {1'b0, y} + {64'd0, c};
    e32 = {33'd0, x[31:0]} + {33'd0, y[31:0]} + {64'd0, c};
    e16 = {49'd0, x[15:0]} + {49'd0, y[15:0]} + {64'd0, c};
    chk({tag, " R1 w32"}, {32'd0, c32, s32}, {32'd0, e32[32:0]});
    chk({tag, " R2 w64"}, {c64, s64}, e64);
    chk({tag, " R7 window at bit0"}, {48'd0, c16a, s16a}, {48'd0, e16[16:0]});
    chk({tag, " R7 window at top"}, {48'd0, c16b, s16b}, {48'd0, e16[16:0]});
    #4;
  endtask

  task automatic chain(int lo, int hi, logic c, string tag);
    logic [63:0] x, y;
    x = '0; y = '0;
    x[lo] = 1'b1; y[lo] = 1'b1;
    for (int k = lo + 1; k <= hi; k++) x[k] = 1'b1;
    apply(x, y, c, tag);
  endtask

  task automatic t_zero;
    apply('0, '0, 1'b0, "zero inputs R1");
  endtask

  task automatic t_full_chain;
    apply('1, '0, 1'b1, "full chain R3");
    chk("R3 w32 sum zero", {33'd0, s32}, 65'd0);
    chk("R3 w32 cout", {64'd0, c32}, 65'd1);
    chk("R3 w64 cout", {64'd0, c64}, 65'd1);
    apply('1, '1, 1'b1, "all ones both R3");
  endtask

  task automatic t_low_into_seg;
    chain(3, 15, 1'b0, "low into window R4");
    chain(0, 17, 1'b1, "cin into window R4");
    chain(10, 31, 1'b0, "low into window64 R4");
  endtask

  task automatic t_seg_to_top;
    chain(14, 31, 1'b0, "window to top R5");
    chain(30, 63, 1'b0, "window to top64 R5");
    chain(19, 31, 1'b1, "window msb to top R5");
  endtask

  task automatic t_seg_pass;
    chain(5, 22, 1'b0, "window pass R6");
    chain(20, 40, 1'b0, "window pass64 R6");
    apply(64'h0000_0000_000F_F000, 64'h0, 1'b0, "window propagate no carry R6");
    apply(64'h0000_000F_F000_0FFF, 64'h0000_0000_0000_0001, 1'b0, "window64 pass R6");
  endtask

  task automatic t_random;
    for (int n = 0; n < 300; n++)
      apply({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), "random R1 R2");
  endtask

  task automatic t_placement;
    chain(0, 15, 1'b0, "bit0 window chain R7");
    chain(2, 12, 1'b1, "top window chain R7");
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    t_zero();
    t_full_chain();
    t_low_into_seg();
    t_seg_to_top();
    t_seg_pass();
    t_placement();
    t_random();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule